// File: doc/BRIEF.md
# Cascadable Quadrature Timer Counter Pair

This block holds two 16-bit up/down counter channels, a lower one and an upper one. Each channel runs in one of two modes. In clock mode it counts up on enable pulses from a shared free-running prescaler. In quadrature mode it decodes a two-phase encoder on its own pair of pins and counts up or down on every edge of either phase.

The upper channel has a clock-select code that makes it count the lower channel's wrap events. In that setting the pair acts as one 32-bit counter, with the lower channel as the low half. The upper half adds one when the lower half wraps from all-ones to zero while counting up. It subtracts one when the lower half wraps from zero to all-ones while counting down. The lower half can only count down in quadrature mode, so only that mode can cause a downward wrap.

Software drives the block through a small write port. The port sets control, start and count registers. Both counts are visible at all times on two output buses.

Top module: `tmr_cascade_pair`

## Requirements
- R1: After reset both counts read 0, both start bits are 0, and both channels are in clock mode with clock-select 3'b000.
- R2: A write to a count register (address 2 for the lower channel, 3 for the upper) loads the written 16-bit value on the next clock edge. The write wins over a count event in the same cycle.
- R3: In clock mode (control bit 3 = 0), clock-select bits [2:0] pick the count rate: 3'b000 counts every cycle, 3'b001 every 4 cycles, 3'b010 every 16 cycles and 3'b011 every 64 cycles. The count only ever goes up in this mode.
- R4: A channel whose start bit is 0 holds its count. The start register is at address 4, with bit 0 for the lower channel and bit 1 for the upper. This holds even when the upper channel is set to count lower-channel wraps.
- R5: In quadrature mode (control bit 3 = 1), each phase pair passes through a two-flop synchronizer. The count changes by one on every valid edge: up when phase A leads phase B (A,B going 00, 10, 11, 01), down when B leads A. The count changes on the third rising clock edge after a pin change.
- R6: A sample in which both phases changed at once changes no count. Decoding then continues from the new phase state.
- R7: With upper clock-select 3'b111 and the upper channel in clock mode, a lower wrap from 16'hFFFF to 16'h0000 adds one to the upper count. The upper count updates on the same edge as the wrap, so {upper, lower} steps by exactly one.
- R8: In the same cascaded setting, a lower wrap from 16'h0000 to 16'hFFFF while counting down in quadrature mode subtracts one from the upper count.
- R9: When the upper channel is in quadrature mode, its clock-select code is ignored. It then counts only its own phase pins, and lower-channel wraps leave it unchanged.
- R10: Control registers are at address 0 (lower) and address 1 (upper). Write-data bits [2:0] are the clock-select code and bit 3 is the quadrature-mode bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| qa_lo | input | 1 | Lower channel encoder phase A |
| qb_lo | input | 1 | Lower channel encoder phase B |
| qa_hi | input | 1 | Upper channel encoder phase A |
| qb_hi | input | 1 | Upper channel encoder phase B |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| count_lo | output | 16 | Lower channel count |
| count_hi | output | 16 | Upper channel count |

## Verification
The bench runs the 32-bit value across both wrap directions and checks that it moves by exactly one on every edge. A design that updated the upper half a cycle late would show a transient value about 65536 away from the correct one. A design that counted only one wrap direction would leave the upper half stuck on underflow.

The bench also writes a count while the lower channel advances every cycle. It steps the encoder with both phases changed at once, and it samples exactly at the synchronizer latency. These catch a lost write priority, a spurious count on invalid transitions, and an extra or missing flop in the decode path.

Two cascade settings are checked for the upper channel: one with a stopped upper channel and one with the upper channel in quadrature mode. In both, a lower wrap must leave the upper count unchanged. This exposes a design that ignores the start bit or obeys the clock-select code when it should not.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CNT_W        = 16;
    localparam int PRESC_STAGES = 4;
    localparam int ADDR_W       = 3;
    localparam int SYNC_STAGES  = 2;

    typedef enum logic [2:0] {
        SEL_DIV1  = 3'd0,
        SEL_DIV4  = 3'd1,
        SEL_DIV16 = 3'd2,
        SEL_DIV64 = 3'd3,
        SEL_RSV4  = 3'd4,
        SEL_RSV5  = 3'd5,
        SEL_RSV6  = 3'd6,
        SEL_CHAIN = 3'd7
    } clk_sel_e;

    typedef struct packed {
        logic     quad;
        clk_sel_e sel;
    } ch_ctrl_t;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL_LO = 3'd0,
        REG_CTRL_HI = 3'd1,
        REG_CNT_LO  = 3'd2,
        REG_CNT_HI  = 3'd3,
        REG_START   = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic step;
        logic up;
    } qstep_t;

    // phases packed as {a, b}
    function automatic qstep_t quad_decode(logic [1:0] prev, logic [1:0] cur);
        qstep_t r;
        logic   a_ch;
        logic   b_ch;
        a_ch   = prev[1] ^ cur[1];
        b_ch   = prev[0] ^ cur[0];
        r.step = a_ch ^ b_ch;
        r.up   = a_ch ? (cur[1] != cur[0]) : (cur[1] == cur[0]);
        return r;
    endfunction

    function automatic logic tick_for(clk_sel_e sel, logic [PRESC_STAGES-1:0] ticks);
        logic t;
        case (sel)
            SEL_DIV1:  t = ticks[0];
            SEL_DIV4:  t = ticks[1];
            SEL_DIV16: t = ticks[2];
            SEL_DIV64: t = ticks[3];
            default:   t = 1'b0;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int STAGES = 4
) (
    input  logic              clk,
    input  logic              rst,
    output logic [STAGES-1:0] ticks
);
    localparam int CW = 2 * (STAGES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + 1'b1;
    end

    assign ticks[0] = 1'b1;

    genvar i;
    generate
        for (i = 1; i < STAGES; i++) begin : g_tick
            assign ticks[i] = &cnt[2*i-1:0];
        end
    endgenerate

endmodule

// File: rtl/tmr_quad_decoder.sv
module tmr_quad_decoder
    import tmr_pkg::*;
#(
    parameter int SYNC = SYNC_STAGES
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   pin_a,
    input  logic   pin_b,
    output qstep_t dq
);
    logic [1:0] sync_q [SYNC];
    logic [1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < SYNC; k++) sync_q[k] <= 2'b00;
            prev_q <= 2'b00;
        end else begin
            sync_q[0] <= {pin_a, pin_b};
            for (int k = 1; k < SYNC; k++) sync_q[k] <= sync_q[k-1];
            prev_q <= sync_q[SYNC-1];
        end
    end

    assign dq = quad_decode(prev_q, sync_q[SYNC-1]);

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         cnt_ev,
    input  logic         cnt_up,
    output logic [W-1:0] count,
    output logic         wrap_up,
    output logic         wrap_dn
);
    localparam logic [W-1:0] ONE = W'(1);
    localparam logic [W-1:0] MAX = '1;

    logic adv;

    assign adv     = run && cnt_ev && !wr_en;
    assign wrap_up = adv &&  cnt_up && (count == MAX);
    assign wrap_dn = adv && !cnt_up && (count == '0);

    always_ff @(posedge clk) begin
        if (rst)         count <= '0;
        else if (wr_en)  count <= wr_data;
        else if (adv)    count <= cnt_up ? count + ONE : count - ONE;
    end

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (count == $past(wr_data)));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_en) |=> $stable(count));

    assert_unit_step_R5: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (count == $past(count) || count == $past(count) + ONE
                    || count == $past(count) - ONE));

endmodule

// File: rtl/tmr_cascade_pair.sv
module tmr_cascade_pair
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              qa_lo,
    input  logic              qb_lo,
    input  logic              qa_hi,
    input  logic              qb_hi,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  count_lo,
    output logic [CNT_W-1:0]  count_hi
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    ch_ctrl_t                ctrl_lo, ctrl_hi;
    logic [1:0]              start;
    logic [PRESC_STAGES-1:0] ticks;
    qstep_t                  dq_lo, dq_hi;
    logic                    wr_lo, wr_hi;
    logic                    lo_ev, lo_up, hi_ev, hi_up;
    logic                    lo_wrap_up, lo_wrap_dn;
    logic                    hi_wrap_up, hi_wrap_dn;
    logic                    chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_lo <= '{quad: 1'b0, sel: SEL_DIV1};
            ctrl_hi <= '{quad: 1'b0, sel: SEL_DIV1};
            start   <= 2'b00;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                REG_CTRL_LO: ctrl_lo <= '{quad: wr_data[3], sel: clk_sel_e'(wr_data[2:0])};
                REG_CTRL_HI: ctrl_hi <= '{quad: wr_data[3], sel: clk_sel_e'(wr_data[2:0])};
                REG_START:   start   <= wr_data[1:0];
                default: ;
            endcase
        end
    end

    assign wr_lo = wr_en && (wr_addr == REG_CNT_LO);
    assign wr_hi = wr_en && (wr_addr == REG_CNT_HI);

    tmr_prescaler #(.STAGES(PRESC_STAGES)) u_presc (
        .clk(clk), .rst(rst), .ticks(ticks)
    );

    tmr_quad_decoder #(.SYNC(SYNC_STAGES)) u_dec_lo (
        .clk(clk), .rst(rst), .pin_a(qa_lo), .pin_b(qb_lo), .dq(dq_lo)
    );

    tmr_quad_decoder #(.SYNC(SYNC_STAGES)) u_dec_hi (
        .clk(clk), .rst(rst), .pin_a(qa_hi), .pin_b(qb_hi), .dq(dq_hi)
    );

    // lower channel source
    always_comb begin
        if (ctrl_lo.quad) begin
            lo_ev = dq_lo.step;
            lo_up = dq_lo.up;
        end else begin
            lo_ev = tick_for(ctrl_lo.sel, ticks);
            lo_up = 1'b1;
        end
    end

    // upper channel source; quadrature mode overrides the select code
    assign chain = !ctrl_hi.quad && (ctrl_hi.sel == SEL_CHAIN);

    always_comb begin
        if (ctrl_hi.quad) begin
            hi_ev = dq_hi.step;
            hi_up = dq_hi.up;
        end else if (chain) begin
            hi_ev = lo_wrap_up || lo_wrap_dn;
            hi_up = lo_wrap_up;
        end else begin
            hi_ev = tick_for(ctrl_hi.sel, ticks);
            hi_up = 1'b1;
        end
    end

    tmr_counter #(.W(CNT_W)) u_cnt_lo (
        .clk(clk), .rst(rst), .run(start[0]), .wr_en(wr_lo), .wr_data(wr_data),
        .cnt_ev(lo_ev), .cnt_up(lo_up), .count(count_lo),
        .wrap_up(lo_wrap_up), .wrap_dn(lo_wrap_dn)
    );

    tmr_counter #(.W(CNT_W)) u_cnt_hi (
        .clk(clk), .rst(rst), .run(start[1]), .wr_en(wr_hi), .wr_data(wr_data),
        .cnt_ev(hi_ev), .cnt_up(hi_up), .count(count_hi),
        .wrap_up(hi_wrap_up), .wrap_dn(hi_wrap_dn)
    );

    assert_carry_R7: assert property (@(posedge clk) disable iff (rst)
        (chain && start[1] && !wr_hi && lo_wrap_up) |=> (count_hi == $past(count_hi) + ONE));

    assert_borrow_R8: assert property (@(posedge clk) disable iff (rst)
        (chain && start[1] && !wr_hi && lo_wrap_dn) |=> (count_hi == $past(count_hi) - ONE));

    assert_up_only_R3: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_lo.quad && !wr_lo) |=> (count_lo == $past(count_lo) || count_lo == $past(count_lo) + ONE));

    assert_quad_isolated_R9: assert property (@(posedge clk) disable iff (rst)
        (ctrl_hi.quad && !wr_hi && !dq_hi.step) |=> $stable(count_hi));

endmodule

// File: tb/sim_tmr_cascade_pair.sv
module sim_tmr_cascade_pair;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        qa_lo = 1'b0, qb_lo = 1'b0, qa_hi = 1'b0, qb_hi = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] count_lo, count_hi;

    int n_run = 0;
    int n_fail = 0;
    int ph_lo = 0;
    int ph_hi = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_cascade_pair u0 (
        .clk(clk), .rst(rst), .qa_lo(qa_lo), .qb_lo(qb_lo), .qa_hi(qa_hi), .qb_hi(qb_hi),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .count_lo(count_lo), .count_hi(count_hi)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [1:0] gray(int idx);
        case (idx & 3)
            0: return 2'b00;
            1: return 2'b10;
            2: return 2'b11;
            default: return 2'b01;
        endcase
    endfunction

    task automatic set_pins(bit hi, int idx);
        logic [1:0] g;
        g = gray(idx);
        if (hi) begin qa_hi = g[1]; qb_hi = g[0]; end
        else    begin qa_lo = g[1]; qb_lo = g[0]; end
    endtask

    task automatic qmove(bit hi, bit up);
        @(negedge clk);
        if (hi) begin ph_hi = up ? ph_hi + 1 : ph_hi + 3; set_pins(1'b1, ph_hi); end
        else    begin ph_lo = up ? ph_lo + 1 : ph_lo + 3; set_pins(1'b0, ph_lo); end
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 lo count", {16'h0, count_lo}, 32'h0);
        check("R1 hi count", {16'h0, count_hi}, 32'h0);
        repeat (5) @(negedge clk);
        check("R1 stopped after reset", {count_hi, count_lo}, 32'h0);
    endtask

    task automatic t_rate(logic [2:0] sel, int div);
        logic [15:0] v0;
        wr(3'd4, 16'h0);
        wr(3'd0, {13'h0, sel});
        wr(3'd4, 16'h1);
        repeat (3) @(negedge clk);
        v0 = count_lo;
        repeat (256) @(negedge clk);
        check($sformatf("R3 R10 rate sel %0d", sel), {16'h0, count_lo - v0}, 32'(256 / div));
    endtask

    task automatic t_write_priority;
        wr(3'd4, 16'h0);
        wr(3'd0, 16'h0);
        wr(3'd4, 16'h1);
        repeat (3) @(negedge clk);
        wr(3'd2, 16'h5555);
        check("R2 load beats count", {16'h0, count_lo}, 32'h5555);
        @(negedge clk);
        check("R2 counts on after load", {16'h0, count_lo}, 32'h5556);
        wr(3'd3, 16'hBEEF);
        check("R2 upper load", {16'h0, count_hi}, 32'hBEEF);
    endtask

    task automatic t_hold;
        logic [15:0] v;
        wr(3'd4, 16'h0);
        v = count_lo;
        repeat (20) @(negedge clk);
        check("R4 stopped holds", {16'h0, count_lo}, {16'h0, v});
    endtask

    task automatic t_quad;
        logic [15:0] v;
        wr(3'd4, 16'h0);
        wr(3'd0, 16'h0008);
        wr(3'd2, 16'h0100);
        wr(3'd4, 16'h1);
        @(negedge clk);
        ph_lo = ph_lo + 1; set_pins(1'b0, ph_lo);
        repeat (2) @(negedge clk);
        check("R5 latency not yet", {16'h0, count_lo}, 32'h0100);
        @(negedge clk);
        check("R5 latency third edge", {16'h0, count_lo}, 32'h0101);
        for (int i = 0; i < 3; i++) qmove(1'b0, 1'b1);
        check("R5 A leads B up", {16'h0, count_lo}, 32'h0104);
        for (int i = 0; i < 6; i++) qmove(1'b0, 1'b0);
        check("R5 B leads A down", {16'h0, count_lo}, 32'h00FE);
        v = count_lo;
        @(negedge clk);
        ph_lo = ph_lo + 2; set_pins(1'b0, ph_lo);
        repeat (5) @(negedge clk);
        check("R6 both phases change no count", {16'h0, count_lo}, {16'h0, v});
        qmove(1'b0, 1'b1);
        check("R6 decode resumes", {16'h0, count_lo}, {16'h0, v + 16'h1});
    endtask

    task automatic t_cascade_ovf;
        logic [31:0] prev;
        wr(3'd4, 16'h0);
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'h0007);
        wr(3'd2, 16'hFFFC);
        wr(3'd3, 16'h1234);
        wr(3'd4, 16'h3);
        for (int i = 0; i < 8; i++) begin
            prev = {count_hi, count_lo};
            @(negedge clk);
            check("R7 32-bit steps by one", {count_hi, count_lo}, prev + 32'd1);
        end
        check("R7 upper carried", {16'h0, count_hi}, 32'h1235);
    endtask

    task automatic t_cascade_unf;
        wr(3'd4, 16'h0);
        wr(3'd0, 16'h0008);
        wr(3'd1, 16'h0007);
        wr(3'd2, 16'h0001);
        wr(3'd3, 16'h0010);
        wr(3'd4, 16'h3);
        qmove(1'b0, 1'b0);
        check("R8 reach zero", {count_hi, count_lo}, 32'h0010_0000);
        qmove(1'b0, 1'b0);
        check("R8 borrow", {count_hi, count_lo}, 32'h000F_FFFF);
        qmove(1'b0, 1'b1);
        check("R7 carry back", {count_hi, count_lo}, 32'h0010_0000);
    endtask

    task automatic t_upper_stopped;
        wr(3'd4, 16'h0);
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'h0007);
        wr(3'd2, 16'hFFF0);
        wr(3'd3, 16'h0200);
        wr(3'd4, 16'h1);
        repeat (40) @(negedge clk);
        check("R4 upper stopped ignores wrap", {16'h0, count_hi}, 32'h0200);
        check("R4 lower wrapped", {31'h0, count_lo < 16'h0100}, 32'h1);
    endtask

    task automatic t_upper_quad;
        wr(3'd4, 16'h0);
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'h000F);
        wr(3'd2, 16'hFFF0);
        wr(3'd3, 16'h0100);
        wr(3'd4, 16'h3);
        repeat (40) @(negedge clk);
        check("R9 select ignored in quad", {16'h0, count_hi}, 32'h0100);
        qmove(1'b1, 1'b1);
        qmove(1'b1, 1'b1);
        check("R9 upper own encoder up", {16'h0, count_hi}, 32'h0102);
        qmove(1'b1, 1'b0);
        check("R9 upper own encoder down", {16'h0, count_hi}, 32'h0101);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_rate(3'd0, 1);
        t_rate(3'd1, 4);
        t_rate(3'd2, 16);
        t_rate(3'd3, 64);
        t_write_priority;
        t_hold;
        t_quad;
        t_cascade_ovf;
        t_cascade_unf;
        t_upper_stopped;
        t_upper_quad;
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule